// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a 128-pin general-purpose I/O controller. The pins are grouped into four banks of 32. For each bank it keeps a direction word, an output latch, rising-edge and falling-edge enable words, and two alternate-function words. Software reaches all of these through a simple word-addressed bus with 32-bit data. Writes are strobed and reads are combinational. The output latch has no direct write path. A bit is raised through a write-only set port and lowered through a write-only clear port, so a driver can change single pins without a read-modify-write.

The block drives the pad output value and the output enable for every pin. It registers the pad inputs once and offers the sampled levels, together with the per-pin edge enables, to a neighbouring edge-detect block. That block owns the edge status bits. This controller returns those bits on a read of a status word, and turns a write to a status word into a one-cycle clear mask sent back to that block. Reading a level word gives, for each pin, the output latch bit if the pin is an output and the sampled pad input if it is an input. The address map is irregular: the fourth bank's words sit in a separate window.

Top module: `gpbank_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared, including the sampled inputs. After that edge `pad_oe`, `pad_out`, `rise_en`, `fall_en` and `pin_level` are all zero, and every mapped read returns zero apart from the edge-status words.
- R2: The direction words are at word addresses 0x03, 0x04, 0x05 and 0x43, for banks 0 to 3. The rising-enable words are at 0x0C, 0x0D, 0x0E and 0x4C. The falling-enable words are at 0x0F, 0x10, 0x11 and 0x4F. Each of these words reads back the last value written to it.
- R3: A write to an output-set word ORs the write data into that bank's output latch. The set words are at 0x06, 0x07, 0x08 and 0x46.
- R4: A write to an output-clear word clears each latch bit that is written as 1 and leaves the other bits unchanged. The clear words are at 0x09, 0x0A, 0x0B and 0x49.
- R5: The output-set and output-clear words always read as zero.
- R6: A read of a level word returns `(latch & dir) | (sampled_input & ~dir)` for that bank. The level words are at 0x00, 0x01, 0x02 and 0x40.
- R7: Pin 32*b+i is driven only when direction bit i of bank b is 1. `pad_oe` equals the direction bits, and `pad_out` equals latch AND direction.
- R8: A read of any word address that is not listed in R2 to R10 returns zero. A write to such an address changes no register.
- R9: The lower alternate-function words are at 0x15, 0x17, 0x19 and 0x1B. The upper alternate-function words are at 0x16, 0x18, 0x1A and 0x1C. Each is separate storage that reads back the last value written to it.
- R10: The edge-status words are at 0x12, 0x13, 0x14 and 0x52. A read returns that bank's slice of `edge_stat`. While a write to one of them is strobed, the bank's slice of `edge_clr` equals the write data. At all other times `edge_clr` is zero.
- R11: `pad_in` is registered once at each clock edge. `pin_level` and the input part of a level read show the value that was captured at the most recent edge.
- R12: `rise_en` and `fall_en` equal the rising-enable and falling-enable registers, with bank b in bits 32*b+31 to 32*b.
- R13: A register write takes effect at the clock edge on which the strobe is sampled, so it is visible from the following cycle. `bus_rdata` follows `bus_addr` within the same cycle, and with no write strobe all stored registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (7) | Word address |
| bus_wdata | input | BANK_W (32) | Write data |
| bus_rdata | output | BANK_W (32) | Read data for the addressed word |
| pad_in | input | 4*BANK_W (128) | Pad input levels |
| pad_out | output | 4*BANK_W (128) | Pad output values |
| pad_oe | output | 4*BANK_W (128) | Pad output enables |
| rise_en | output | 4*BANK_W (128) | Rising-edge enables to the edge-detect block |
| fall_en | output | 4*BANK_W (128) | Falling-edge enables to the edge-detect block |
| pin_level | output | 4*BANK_W (128) | Sampled pad inputs to the edge-detect block |
| edge_stat | input | 4*BANK_W (128) | Edge status from the edge-detect block |
| edge_clr | output | 4*BANK_W (128) | Write-1-to-clear mask for edge status |

## Verification
The bench builds the block with its default parameters, BANK_W = 32 and ADDR_W = 7. This gives the full 128-pin, four-bank layout and a 128-word address space that can be swept end to end. The sweep covers the separate window of the fourth bank, the packed alternate-function block, and the unmapped holes between and above them. Because every word is visited, the bench can read back after writes to holes and after set/clear writes that overlap each other on all four banks. A behavioural model compares all outputs against the design on every cycle, under random pad levels and random edge-status inputs.

// File: rtl/gpbank_pkg.sv
// Shared types for the banked GPIO register controller.
// Assumes four banks; register kinds 0..6 follow the address order
// within each bank group, which the decoder relies on.
package gpbank_pkg;

    typedef enum logic [3:0] {
        RK_LEVEL = 4'd0,
        RK_DIR   = 4'd1,
        RK_OSET  = 4'd2,
        RK_OCLR  = 4'd3,
        RK_RISE  = 4'd4,
        RK_FALL  = 4'd5,
        RK_EDGE  = 4'd6,
        RK_AFLO  = 4'd7,
        RK_AFHI  = 4'd8,
        RK_NONE  = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [1:0] bank;
    } reg_sel_t;

    localparam int NUM_BANKS = 4;

endpackage

// File: rtl/gpbank_decode.sv
// Address decoder: maps a word address to a register kind and a bank.
// Banks 0..2 of the seven per-bank kinds are packed at three words per
// kind from 0; bank 3 sits in a window at HI_BASE with the same stride;
// the eight alternate-function words follow the low group, lower/upper
// interleaved per bank. Assumes ADDR_W >= 7.
module gpbank_decode
    import gpbank_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int KINDS    = 7;
    localparam int LOW_BKS  = 3;
    localparam int AF_BASE  = KINDS * LOW_BKS;
    localparam int AF_WORDS = 2 * NUM_BANKS;
    localparam int HI_BASE  = 'h40;

    // Purpose: compare the address against every mapped word.
    always_comb begin
        sel = '{hit: 1'b0, kind: RK_NONE, bank: 2'd0};
        for (int k = 0; k < KINDS; k++) begin
            for (int b = 0; b < LOW_BKS; b++) begin
                if (addr == ADDR_W'(k * LOW_BKS + b)) begin
                    sel = '{hit: 1'b1, kind: reg_kind_e'(4'(k)), bank: 2'(b)};
                end
            end
            if (addr == ADDR_W'(HI_BASE + k * LOW_BKS)) begin
                sel = '{hit: 1'b1, kind: reg_kind_e'(4'(k)), bank: 2'd3};
            end
        end
        for (int a = 0; a < AF_WORDS; a++) begin
            if (addr == ADDR_W'(AF_BASE + a)) begin
                sel = '{hit: 1'b1, kind: ((a % 2) == 1) ? RK_AFHI : RK_AFLO,
                        bank: 2'(a / 2)};
            end
        end
    end

endmodule

// File: rtl/gpbank_slice.sv
// One bank of registers: direction, output latch, edge enables, two
// alternate-function words and the sampled pad inputs. Assumes the
// caller qualifies wr_en with the bank select; kind is shared by banks.
module gpbank_slice
    import gpbank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] edge_stat,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q,
    output logic [W-1:0] smp_q,
    output logic [W-1:0] rd_word
);
    logic [W-1:0] aflo_q;
    logic [W-1:0] afhi_q;

    // Purpose: reset, input sampling and strobed register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            lat_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            aflo_q <= '0;
            afhi_q <= '0;
            smp_q  <= '0;
        end else begin
            smp_q <= pad_in;
            if (wr_en) begin
                case (kind)
                    RK_DIR:  dir_q  <= wdata;
                    RK_OSET: lat_q  <= lat_q | wdata;
                    RK_OCLR: lat_q  <= lat_q & ~wdata;
                    RK_RISE: rise_q <= wdata;
                    RK_FALL: fall_q <= wdata;
                    RK_AFLO: aflo_q <= wdata;
                    RK_AFHI: afhi_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Purpose: select this bank's read word for the addressed kind.
    always_comb begin
        case (kind)
            RK_LEVEL: rd_word = (lat_q & dir_q) | (smp_q & ~dir_q);
            RK_DIR:   rd_word = dir_q;
            RK_RISE:  rd_word = rise_q;
            RK_FALL:  rd_word = fall_q;
            RK_EDGE:  rd_word = edge_stat;
            RK_AFLO:  rd_word = aflo_q;
            RK_AFHI:  rd_word = afhi_q;
            default:  rd_word = '0;
        endcase
    end

    assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_OSET) |=> ((lat_q & $past(wdata)) == $past(wdata)));

    assert_clr_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_OCLR) |=> ((lat_q & $past(wdata)) == '0));

    assert_dir_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en) |=> $stable(dir_q));

    assert_lat_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en) |=> $stable(lat_q));

endmodule

// File: rtl/gpbank_ctrl.sv
// Top of the banked GPIO register controller. Decodes the bus address,
// fans writes out to four bank slices, muxes reads back and drives the
// pad and edge-detect interfaces. Assumes reads are combinational and
// writes land on the edge that samples the strobe.
module gpbank_ctrl
    import gpbank_pkg::*;
#(
    parameter int BANK_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BANK_W-1:0]        bus_wdata,
    output logic [BANK_W-1:0]        bus_rdata,
    input  logic [4*BANK_W-1:0]      pad_in,
    output logic [4*BANK_W-1:0]      pad_out,
    output logic [4*BANK_W-1:0]      pad_oe,
    output logic [4*BANK_W-1:0]      rise_en,
    output logic [4*BANK_W-1:0]      fall_en,
    output logic [4*BANK_W-1:0]      pin_level,
    input  logic [4*BANK_W-1:0]      edge_stat,
    output logic [4*BANK_W-1:0]      edge_clr
);
    localparam int NB = NUM_BANKS;

    reg_sel_t          dsel;
    logic              wr_go;
    logic [BANK_W-1:0] rd_bank [NB];

    gpbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (dsel)
    );

    assign wr_go = bus_sel && bus_wr && dsel.hit;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic              bank_wr;
        logic [BANK_W-1:0] dir_w;
        logic [BANK_W-1:0] lat_w;

        assign bank_wr = wr_go && (dsel.bank == 2'(b));

        gpbank_slice #(.W(BANK_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bank_wr),
            .kind      (dsel.kind),
            .wdata     (bus_wdata),
            .pad_in    (pad_in[b*BANK_W +: BANK_W]),
            .edge_stat (edge_stat[b*BANK_W +: BANK_W]),
            .dir_q     (dir_w),
            .lat_q     (lat_w),
            .rise_q    (rise_en[b*BANK_W +: BANK_W]),
            .fall_q    (fall_en[b*BANK_W +: BANK_W]),
            .smp_q     (pin_level[b*BANK_W +: BANK_W]),
            .rd_word   (rd_bank[b])
        );

        assign pad_oe[b*BANK_W +: BANK_W]   = dir_w;
        assign pad_out[b*BANK_W +: BANK_W]  = lat_w & dir_w;
        assign edge_clr[b*BANK_W +: BANK_W] =
            (bank_wr && dsel.kind == RK_EDGE) ? bus_wdata : '0;
    end

    assign bus_rdata = dsel.hit ? rd_bank[dsel.bank] : '0;

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dsel.hit |-> (bus_rdata == '0));

    assert_wo_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel.hit && (dsel.kind == RK_OSET || dsel.kind == RK_OCLR)) |-> (bus_rdata == '0));

    assert_drive_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    assert_clr_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_clr != '0) |-> (bus_sel && bus_wr));

endmodule

// File: tb/gpbank_ctrl_test.sv
`timescale 1ns/1ps
module gpbank_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_sel, bus_wr;
    logic [6:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [127:0] pad_in, pad_out, pad_oe, rise_en, fall_en, pin_level;
    logic [127:0] edge_stat, edge_clr;

    int vectors = 0;
    int miscompares = 0;

    gpbank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .rise_en(rise_en), .fall_en(fall_en), .pin_level(pin_level),
        .edge_stat(edge_stat), .edge_clr(edge_clr)
    );

    always #10 clk = ~clk;

    // Reference model state
    logic [31:0] m_dir [4], m_lat [4], m_rise [4], m_fall [4];
    logic [31:0] m_aflo [4], m_afhi [4], m_smp [4];

    // Byte offsets per kind: 0 level,1 dir,2 set,3 clr,4 rise,5 fall,6 edge,7 af-lo,8 af-hi
    function automatic int off_of(int kind, int bank);
        int t [9][4];
        t[0] = '{'h000, 'h004, 'h008, 'h100};
        t[1] = '{'h00C, 'h010, 'h014, 'h10C};
        t[2] = '{'h018, 'h01C, 'h020, 'h118};
        t[3] = '{'h024, 'h028, 'h02C, 'h124};
        t[4] = '{'h030, 'h034, 'h038, 'h130};
        t[5] = '{'h03C, 'h040, 'h044, 'h13C};
        t[6] = '{'h048, 'h04C, 'h050, 'h148};
        t[7] = '{'h054, 'h05C, 'h064, 'h06C};
        t[8] = '{'h058, 'h060, 'h068, 'h070};
        return t[kind][bank];
    endfunction

    function automatic void ref_decode(input int waddr, output int kind, output int bank);
        kind = -1; bank = 0;
        for (int k = 0; k < 9; k++)
            for (int b = 0; b < 4; b++)
                if (off_of(k, b) == waddr * 4) begin kind = k; bank = b; end
    endfunction

    task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model, then advance one clock.
    task automatic step(input string tag);
        int k, b;
        logic [31:0]  er;
        logic [127:0] e_oe, e_out, e_r, e_f, e_lv, e_clr;
        #1;
        ref_decode(int'(bus_addr), k, b);
        case (k)
            0: er = (m_lat[b] & m_dir[b]) | (m_smp[b] & ~m_dir[b]);
            1: er = m_dir[b];
            4: er = m_rise[b];
            5: er = m_fall[b];
            6: er = edge_stat[b*32 +: 32];
            7: er = m_aflo[b];
            8: er = m_afhi[b];
            default: er = 32'h0;
        endcase
        e_clr = '0;
        if (bus_sel && bus_wr && k == 6) e_clr[b*32 +: 32] = bus_wdata;
        for (int i = 0; i < 4; i++) begin
            e_oe[i*32 +: 32]  = m_dir[i];
            e_out[i*32 +: 32] = m_lat[i] & m_dir[i];
            e_r[i*32 +: 32]   = m_rise[i];
            e_f[i*32 +: 32]   = m_fall[i];
            e_lv[i*32 +: 32]  = m_smp[i];
        end
        check(tag, "rdata", {96'h0, bus_rdata}, {96'h0, er});
        check(tag, "pad_oe", pad_oe, e_oe);
        check(tag, "pad_out", pad_out, e_out);
        check(tag, "rise_en", rise_en, e_r);
        check(tag, "fall_en", fall_en, e_f);
        check(tag, "pin_level", pin_level, e_lv);
        check(tag, "edge_clr", edge_clr, e_clr);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_dir[i] = 0; m_lat[i] = 0; m_rise[i] = 0; m_fall[i] = 0;
                m_aflo[i] = 0; m_afhi[i] = 0; m_smp[i] = 0;
            end
        end else begin
            for (int i = 0; i < 4; i++) m_smp[i] = pad_in[i*32 +: 32];
            if (bus_sel && bus_wr) begin
                case (k)
                    1: m_dir[b]  = bus_wdata;
                    2: m_lat[b]  = m_lat[b] | bus_wdata;
                    3: m_lat[b]  = m_lat[b] & ~bus_wdata;
                    4: m_rise[b] = bus_wdata;
                    5: m_fall[b] = bus_wdata;
                    7: m_aflo[b] = bus_wdata;
                    8: m_afhi[b] = bus_wdata;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input int waddr, input logic [31:0] d, input string tag);
        bus_sel = 1; bus_wr = 1; bus_addr = 7'(waddr); bus_wdata = d;
        step(tag);
    endtask

    task automatic rd(input int waddr, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = 7'(waddr); bus_wdata = $urandom;
        step(tag);
    endtask

    function automatic int waddr_of(int kind, int bank);
        return off_of(kind, bank) / 4;
    endfunction

    initial begin
        #(20 * 190000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int k, b;
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        pad_in = {4{32'hA5A5_5A5A}}; edge_stat = '0;
        for (int i = 0; i < 4; i++) begin
            m_dir[i] = 0; m_lat[i] = 0; m_rise[i] = 0; m_fall[i] = 0;
            m_aflo[i] = 0; m_afhi[i] = 0; m_smp[i] = 0;
        end
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R1: reset state held
        for (int i = 0; i < 3; i++) step("R1 reset");
        rst_n = 1;
        for (int i = 0; i < 4; i++) rd(waddr_of(1, i), "R1 reset readback");

        // R2: direction and enable words
        for (int i = 0; i < 4; i++) begin
            wr(waddr_of(1, i), 32'h0000_FFFF ^ (32'h1111_0000 * (i + 1)), "R2 dir write");
            wr(waddr_of(4, i), 32'hC3C3_0000 + i, "R12 rise write");
            wr(waddr_of(5, i), 32'h0F0F_1000 + i, "R12 fall write");
        end
        for (int i = 0; i < 4; i++)
            for (int kk = 1; kk < 6; kk++) rd(waddr_of(kk, i), "R2 readback");

        // R3 / R4: set and clear on each bank
        for (int i = 0; i < 4; i++) begin
            wr(waddr_of(2, i), 32'h0000_00F0, "R3 set");
            wr(waddr_of(2, i), 32'hF000_0001, "R3 set accumulate");
            wr(waddr_of(3, i), 32'h1000_0030, "R4 clear");
            rd(waddr_of(0, i), "R6 level after clear");
            wr(waddr_of(3, i), 32'h0000_0000, "R4 clear zero");
        end
        // R5: write-only words read zero
        for (int i = 0; i < 4; i++) begin
            rd(waddr_of(2, i), "R5 set reads zero");
            rd(waddr_of(3, i), "R5 clear reads zero");
        end

        // R6 / R7 / R11: mixed direction with random pad input
        for (int n = 0; n < 40; n++) begin
            pad_in = {$urandom, $urandom, $urandom, $urandom};
            k = n % 4;
            if (n % 5 == 0) wr(waddr_of(1, k), $urandom, "R7 dir change");
            else if (n % 5 == 1) wr(waddr_of(2, k), $urandom, "R7 set");
            else rd(waddr_of(0, k), "R6 R11 level read");
        end

        // R9: alternate-function storage
        for (int i = 0; i < 4; i++) begin
            wr(waddr_of(7, i), 32'hAF00_0000 + i, "R9 af low");
            wr(waddr_of(8, i), 32'hBF00_0000 + i, "R9 af high");
        end
        for (int a = 'h15; a <= 'h1C; a++) rd(a, "R9 af readback");

        // R10: edge status read and clear mask
        for (int i = 0; i < 4; i++) begin
            edge_stat = {$urandom, $urandom, $urandom, $urandom};
            rd(waddr_of(6, i), "R10 edge read");
            wr(waddr_of(6, i), $urandom, "R10 edge clear");
        end

        // R8: full sweep, writes to holes, sweep again
        for (int a = 0; a < 128; a++) rd(a, "R8 sweep");
        for (int a = 0; a < 128; a++) begin
            ref_decode(a, k, b);
            if (k < 0) wr(a, 32'hFFFF_FFFF, "R8 hole write");
        end
        for (int a = 0; a < 128; a++) rd(a, "R8 sweep after hole writes");

        // R13: random traffic including idle cycles
        for (int n = 0; n < 600; n++) begin
            pad_in = {$urandom, $urandom, $urandom, $urandom};
            edge_stat = {$urandom, $urandom, $urandom, $urandom};
            bus_sel = ($urandom % 4) != 0;
            bus_wr = $urandom % 2;
            bus_addr = 7'($urandom);
            bus_wdata = $urandom;
            step("R13 random");
        end
        bus_sel = 0; bus_wr = 0;
        for (int i = 0; i < 4; i++) step("R13 idle hold");

        // R1 again: reset from a busy state
        rst_n = 0;
        step("R1 reset mid-run");
        rst_n = 1;
        for (int i = 0; i < 4; i++) rd(waddr_of(7, i), "R1 af cleared");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule